// File: doc/BRIEF.md
# Pulse Accumulator with Event Flags

This block counts events on one external input. In event mode each chosen edge of the pin adds one to the count. In gated time mode the count adds one for each prescaled tick that arrives while the pin is at its active level. The count is one 16-bit register. In split mode that register works as two 8-bit halves: the upper half takes the increments and the lower half counts how often the upper half rolls over.

Two flags record what has happened. The overflow flag marks a rollover and the hit flag marks an input edge. Each flag has its own interrupt enable, and the interrupt output is the OR of the enabled flags. Software clears a flag by writing a one to it. With fast clearing turned on, clearing happens instead as a side effect of accessing the count register.

The bus has no wait states. A write takes effect at the next clock edge. Read data is combinational from the address.

Top module: `pulse_acc`

Register map. The address is 2 bits wide.

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 `en`, bit1 `gated` (1 = gated time mode), bit2 `pol`, bit3 `split`, bit4 `sat`, bit5 `fast_clr`, bit6 overflow interrupt enable, bit7 hit interrupt enable |
| 1 | FLAGS | bit0 hit flag, bit1 overflow flag |
| 2 | COUNT | the 16-bit count |
| 3 | none | reads as zero |

## Requirements
- R1: After a synchronous reset, CTRL, FLAGS and COUNT read 0 and `irq` is 0. Address 3 always reads 0.
- R2: In event mode (CTRL bit1 = 0), each edge of `pin` of the selected polarity adds one to COUNT and sets FLAGS bit0. The polarity bit is CTRL bit2: 1 selects rising edges and 0 selects falling edges. The result is visible after the third rising clock edge that follows the pin change.
- R3: In gated time mode (CTRL bit1 = 1), COUNT adds one on each clock where `tick_en` is 1 and the synchronized pin equals CTRL bit2. The trailing edge of the gate (the pin leaving its active level) sets FLAGS bit0.
- R4: In 16-bit mode (CTRL bit3 = 0), an increment from 0xFFFF gives 0x0000 and sets FLAGS bit1.
- R5: In split mode (CTRL bit3 = 1, bit4 = 0), increments go to COUNT[15:8]. An increment at 0xFF wraps the upper half to 0x00, adds one to COUNT[7:0] and sets FLAGS bit1.
- R6: In split mode with saturation (CTRL bit4 = 1), an increment while COUNT[15:8] is 0xFF sets FLAGS bit1 and leaves the whole of COUNT unchanged.
- R7: With CTRL bit5 = 0, writing FLAGS clears each flag whose write bit is 1. Bits written as 0 leave their flags unchanged.
- R8: With CTRL bit5 = 1, writes to FLAGS change nothing. A write to COUNT clears the overflow flag only. A read of COUNT clears both flags.
- R9: FLAGS bits 15:2 always read 0, even after a write of all ones.
- R10: `irq` = (FLAGS bit1 AND CTRL bit6) OR (FLAGS bit0 AND CTRL bit7).
- R11: If a flag is set and cleared in the same cycle, it ends up set.
- R12: With CTRL bit0 = 0, input edges and ticks change neither COUNT nor FLAGS.
- R13: A write to COUNT loads the written value. If an increment falls in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; drives the fast clearing side effects |
| rdata | output | 16 | Read data, combinational from `addr` |
| pin | input | 1 | Asynchronous event or gate input |
| tick_en | input | 1 | Prescaled clock enable for gated time mode |
| irq | output | 1 | Interrupt request |

## Verification
A pin change reaches COUNT and FLAGS on the third rising clock edge after it. The bench therefore holds each pin level for four clocks and reads only after the last level has settled. Bus writes are visible from the next edge, and the interrupt output follows its flags on that same edge. A behavioural model in the bench advances on every clock edge, and the interrupt output is compared with it two nanoseconds after each edge. Same-cycle races between an edge and a clear, or between an edge and a load, are set up by asserting the bus strobe exactly two clocks after the pin change, so that both land on the same edge.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int CTRL_W = 8;
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_FLAGS = 2'd1;
    localparam logic [1:0] A_COUNT = 2'd2;

    // Packed control word: the first field is the MSB (bit 7).
    typedef struct packed {
        logic hit_ie;
        logic ovf_ie;
        logic fast_clr;
        logic sat;
        logic split;
        logic pol;
        logic gated;
        logic en;
    } ctrl_t;

    // Flag word: overflow in bit 1, hit in bit 0.
    typedef struct packed {
        logic ovf;
        logic hit;
    } flags_t;

    // Chooses the rising or falling strobe according to polarity.
    function automatic logic pick_edge(logic pol, logic rise, logic fall);
        return pol ? rise : fall;
    endfunction

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~prev_q;
    assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             split,
    input  logic             sat,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);
    localparam int HW = CNT_W / 2;

    logic [CNT_W-1:0] count_q, count_d;
    logic [HW-1:0]    hi, lo;

    assign hi = count_q[CNT_W-1:HW];
    assign lo = count_q[HW-1:0];

    always_comb begin
        count_d = count_q;
        ovf_evt = 1'b0;
        if (load) begin
            count_d = load_val;
        end else if (inc) begin
            if (!split) begin
                {ovf_evt, count_d} = {1'b0, count_q} + (CNT_W+1)'(1);
            end else if (hi != {HW{1'b1}}) begin
                count_d = {hi + HW'(1), lo};
            end else begin
                ovf_evt = 1'b1;
                if (!sat) count_d = {{HW{1'b0}}, lo + HW'(1)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;

    // R4: a full-width increment from all ones lands on zero
    p_wrap16_r4: assert property (@(posedge clk) disable iff (rst)
        (!split && inc && !load && count_q == {CNT_W{1'b1}}) |=> (count_q == '0));

    // R6: the saturating upper half holds at its maximum
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (split && sat && inc && !load && hi == {HW{1'b1}}) |=> $stable(count_q));
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags
    import pacc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fast_clr,
    input  logic   flag_wr,
    input  flags_t flag_wdata,
    input  logic   acc_rd,
    input  logic   acc_wr,
    input  logic   set_ovf,
    input  logic   set_hit,
    input  logic   ovf_ie,
    input  logic   hit_ie,
    output flags_t flags,
    output logic   irq
);
    flags_t flags_q, clr;

    always_comb begin
        if (fast_clr) begin
            clr.ovf = acc_rd | acc_wr;
            clr.hit = acc_rd;
        end else begin
            clr.ovf = flag_wr & flag_wdata.ovf;
            clr.hit = flag_wr & flag_wdata.hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.ovf <= set_ovf | (flags_q.ovf & ~clr.ovf);
            flags_q.hit <= set_hit | (flags_q.hit & ~clr.hit);
        end
    end

    assign flags = flags_q;
    assign irq   = (flags_q.ovf & ovf_ie) | (flags_q.hit & hit_ie);

    // R11: a set in the same cycle as a clear leaves the flag set
    p_set_wins_ovf_r11: assert property (@(posedge clk) disable iff (rst)
        set_ovf |=> flags_q.ovf);
    p_set_wins_hit_r11: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> flags_q.hit);

    // R8: with fast clearing on, a flag write without a count access changes nothing
    p_fast_blocks_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (fast_clr && flag_wr && !acc_rd && !acc_wr && !set_ovf && !set_hit)
        |=> $stable(flags_q));
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pacc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  rdata,
    input  logic              pin,
    input  logic              tick_en,
    output logic              irq
);
    ctrl_t            ctrl_q;
    flags_t           flags;
    logic             lvl, rise, fall;
    logic             inc, set_hit, ovf_evt;
    logic             sel_ctrl, sel_flags, sel_count;
    logic [CNT_W-1:0] count;

    assign sel_ctrl  = (addr == ADDR_W'(A_CTRL));
    assign sel_flags = (addr == ADDR_W'(A_FLAGS));
    assign sel_count = (addr == ADDR_W'(A_COUNT));

    always_ff @(posedge clk) begin
        if (rst)                  ctrl_q <= '0;
        else if (wr_en && sel_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    pacc_sync u_sync (
        .clk (clk),
        .rst (rst),
        .pin (pin),
        .lvl (lvl),
        .rise(rise),
        .fall(fall)
    );

    // Increment source and hit event for the selected mode
    always_comb begin
        if (ctrl_q.gated) begin
            inc     = ctrl_q.en & tick_en & (lvl == ctrl_q.pol);
            set_hit = ctrl_q.en & pick_edge(~ctrl_q.pol, rise, fall);
        end else begin
            inc     = ctrl_q.en & pick_edge(ctrl_q.pol, rise, fall);
            set_hit = inc;
        end
    end

    pacc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .split   (ctrl_q.split),
        .sat     (ctrl_q.sat),
        .load    (wr_en & sel_count),
        .load_val(wdata),
        .count   (count),
        .ovf_evt (ovf_evt)
    );

    pacc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .fast_clr  (ctrl_q.fast_clr),
        .flag_wr   (wr_en & sel_flags),
        .flag_wdata(flags_t'(wdata[1:0])),
        .acc_rd    (rd_en & sel_count),
        .acc_wr    (wr_en & sel_count),
        .set_ovf   (ovf_evt),
        .set_hit   (set_hit),
        .ovf_ie    (ctrl_q.ovf_ie),
        .hit_ie    (ctrl_q.hit_ie),
        .flags     (flags),
        .irq       (irq)
    );

    always_comb begin
        if (sel_ctrl)       rdata = CNT_W'(ctrl_q);
        else if (sel_flags) rdata = CNT_W'(flags);
        else if (sel_count) rdata = count;
        else                rdata = '0;
    end

    // R13: a count write lands regardless of a same-cycle increment
    p_load_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_count) |=> (count == $past(wdata)));

    // R12: a disabled block never moves its count
    p_idle_when_off_r12: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !(wr_en && sel_count)) |=> $stable(count));
endmodule

// File: tb/pulse_acc_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pin = 1'b0, tick_en = 1'b0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference state
    int m_ctrl = 0, m_cnt = 0, m_ovf = 0, m_hit = 0, m_irq = 0;
    int pq[$];

    always #4 clk = ~clk;

    pulse_acc dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .pin(pin), .tick_en(tick_en), .irq(irq)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int bitv(int v, int b);
        return (v >> b) & 1;
    endfunction

    function automatic int model_rd(int a);
        if (a == 0) return m_ctrl;
        if (a == 1) return m_ovf * 2 + m_hit;
        if (a == 2) return m_cnt;
        return 0;
    endfunction

    // Reference model: one step per rising edge, compared 2 ns later
    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_ovf = 0; m_hit = 0;
            pq = '{0, 0, 0};
        end else begin
            int lvl, old, rise, fall, en, gated, pol, ev, tr, inc, hs, os, hi, lo, nc, co, ch, fast;
            lvl = pq[1]; old = pq[2];
            rise = (lvl == 1 && old == 0); fall = (lvl == 0 && old == 1);
            en = bitv(m_ctrl, 0); gated = bitv(m_ctrl, 1); pol = bitv(m_ctrl, 2);
            fast = bitv(m_ctrl, 5);
            ev = pol ? rise : fall;
            tr = pol ? fall : rise;
            inc = en && (gated ? (tick_en && lvl == pol) : ev);
            hs  = en && (gated ? tr : ev);
            os = 0; nc = m_cnt;
            if (wr_en && addr == 2) nc = wdata;
            else if (inc) begin
                if (!bitv(m_ctrl, 3)) begin
                    if (m_cnt == 65535) begin os = 1; nc = 0; end
                    else nc = m_cnt + 1;
                end else begin
                    hi = m_cnt / 256; lo = m_cnt % 256;
                    if (hi < 255) nc = m_cnt + 256;
                    else begin
                        os = 1;
                        if (!bitv(m_ctrl, 4)) nc = (lo + 1) % 256;
                    end
                end
            end
            if (fast) begin
                co = (addr == 2) && (rd_en || wr_en);
                ch = (addr == 2) && rd_en;
            end else begin
                co = wr_en && addr == 1 && wdata[1];
                ch = wr_en && addr == 1 && wdata[0];
            end
            m_ovf = os ? 1 : (co ? 0 : m_ovf);
            m_hit = hs ? 1 : (ch ? 0 : m_hit);
            m_cnt = nc;
            if (wr_en && addr == 0) m_ctrl = wdata % 256;
        end
        pq.push_front(rst ? 0 : int'(pin));
        void'(pq.pop_back());
        m_irq = (m_ovf && bitv(m_ctrl, 6)) || (m_hit && bitv(m_ctrl, 7));
        #2;
        chk("R10 irq vs model", {15'd0, irq}, 16'(m_irq));
    end

    // Prescaled tick: one cycle in three
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            tick_en = (n % 3 == 0);
            n++;
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1;
        chk(tag, rdata, exp);
        chk({tag, " model"}, rdata, 16'(model_rd(int'(a))));
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_model(logic [1:0] a, string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1;
        chk(tag, rdata, 16'(model_rd(int'(a))));
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin = 1'b1;
            repeat (4) @(negedge clk);
            pin = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd(0, 16'h0000, "R1 ctrl reset");
        rd(1, 16'h0000, "R1 flags reset");
        rd(2, 16'h0000, "R1 count reset");
        rd(3, 16'h0000, "R1 unused address");
        chk("R1 irq reset", {15'd0, irq}, 16'h0000);

        // R2 rising edges
        wr(0, 16'h0005);
        pulses(3);
        rd(2, 16'h0003, "R2 rising count");
        rd(1, 16'h0001, "R2 hit flag");
        // R7 write-one-to-clear
        wr(1, 16'h0000);
        rd(1, 16'h0001, "R7 zero write keeps flag");
        wr(1, 16'h0001);
        rd(1, 16'h0000, "R7 one write clears flag");
        // R2 falling edges
        wr(0, 16'h0001);
        pulses(2);
        rd(2, 16'h0005, "R2 falling count");
        wr(1, 16'h0003);
        // R12 disabled
        wr(0, 16'h0004);
        pulses(2);
        rd(2, 16'h0005, "R12 count held");
        rd(1, 16'h0000, "R12 flags held");

        // R4 16-bit wrap with R10 interrupt
        wr(2, 16'hFFFE);
        wr(0, 16'h0045);
        pulses(2);
        rd(2, 16'h0000, "R4 wrap to zero");
        rd(1, 16'h0003, "R4 overflow flag");
        chk("R10 irq on overflow", {15'd0, irq}, 16'h0001);
        wr(0, 16'h0085);
        wr(1, 16'h0002);
        rd(1, 16'h0001, "R7 clear only overflow");
        chk("R10 irq from hit", {15'd0, irq}, 16'h0001);
        wr(1, 16'h0001);
        chk("R10 irq drops", {15'd0, irq}, 16'h0000);

        // R5 split wrap
        wr(2, 16'hFE03);
        wr(0, 16'h000D);
        pulses(2);
        rd(2, 16'h0004, "R5 split wrap");
        rd(1, 16'h0003, "R5 overflow flag");
        wr(1, 16'h0003);
        // R6 saturation
        wr(2, 16'hFE07);
        wr(0, 16'h001D);
        pulses(3);
        rd(2, 16'hFF07, "R6 saturated count");
        rd(1, 16'h0003, "R6 overflow flag");
        wr(1, 16'h0003);

        // R3 gated time
        wr(2, 16'h0000);
        wr(0, 16'h0007);
        @(negedge clk); pin = 1'b1;
        repeat (20) @(negedge clk);
        pin = 1'b0;
        repeat (10) @(negedge clk);
        rd_model(2, "R3 gated count");
        rd(1, 16'h0001, "R3 trailing edge flag");
        wr(1, 16'h0003);

        // R8 fast clearing
        wr(0, 16'h0005);
        wr(2, 16'hFFFF);
        pulses(1);
        wr(0, 16'h0025);
        wr(1, 16'h0003);
        rd(1, 16'h0003, "R8 write ignored");
        wr(2, 16'h1234);
        rd(1, 16'h0001, "R8 count write clears overflow");
        rd(2, 16'h1234, "R8 count read");
        rd(1, 16'h0000, "R8 count read clears hit");

        // R11 set beats fast clear on the same edge
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 2; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(1, 16'h0001, "R11 set wins over clear");
        @(negedge clk); pin = 1'b0;
        repeat (4) @(negedge clk);

        // R13 load beats increment
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 2; wdata = 16'h0100; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(0, 16'h0025, "R13 ctrl unchanged");
        @(negedge clk); addr = 2; #1;
        chk("R13 load wins", rdata, 16'h0100);
        @(negedge clk); pin = 1'b0;
        repeat (4) @(negedge clk);

        // R9 unused flag bits
        wr(0, 16'h0005);
        wr(1, 16'hFFFF);
        rd(1, 16'h0000, "R9 unused bits zero");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule